// File: doc/BRIEF.md
# Autoreload Timebase Upcounter

This block is a free-running up-counter for periodic timebase events. It advances by one on each cycle where a divide-by-32 clock enable is high, and when it steps past its all-ones value it does not return to zero. Instead it restarts from a programmable start value held in a reload register. The period between overflow events is therefore set by software as the distance from that start value to all-ones, plus one.

Each wrap sets an overflow flag in a small status word. If the interrupt enable bit is also set, the interrupt output rises. Software clears the flag by reading the status word. The reload register can be rewritten at any moment, but the counter only picks up a new start value at the next wrap, so the period in progress is never cut short. A halt input freezes counting, which is how a full stop of the oscillator is modelled.

Top module: `tbase_reload_counter`

## Requirements
- R1: After reset the counter reads 00h, the reload register holds 00h, and both status bits are 0. The status word is bit 0 = overflow flag and bit 1 = interrupt enable. The interrupt output is 0.
- R2: On a clock edge where `tick_i` is 1 and `halt_i` is 0, the counter rises by one unless it is at FFh. When `tick_i` is 0 the counter holds.
- R3: On an advancing edge where the counter is at FFh, the counter loads the reload register value instead of 00h, and the overflow flag is set.
- R4: A reload write does not change the counter. The new value is used at the first wrap after the write. A write on the same edge as a wrap leaves that wrap using the previously held value.
- R5: While `halt_i` is 1 the counter and the overflow flag do not change through counting, even when `tick_i` pulses.
- R6: A status read (`stat_rd_i` high for one edge) returns the current status on `stat_o` and clears the overflow flag on that edge.
- R7: If a wrap and a status read fall on the same edge, the overflow flag stays set.
- R8: `irq_o` is 1 exactly when the overflow flag and the interrupt enable bit are both 1. The enable bit is written through `ie_wr_i`/`ie_wdata_i`.
- R9: With a reload value of FFh, every advancing edge is a wrap: the counter stays at FFh and the flag is set on each tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle enable at oscillator/32 rate |
| halt_i | input | 1 | Freezes counting while high |
| arr_wr_i | input | 1 | Reload register write strobe |
| arr_wdata_i | input | CNT_W | Reload register write data |
| ie_wr_i | input | 1 | Interrupt enable write strobe |
| ie_wdata_i | input | 1 | Interrupt enable write data |
| stat_rd_i | input | 1 | Status read strobe (clears flag) |
| cnt_o | output | CNT_W | Current counter value |
| stat_o | output | 2 | Status word: bit 0 flag, bit 1 enable |
| irq_o | output | 1 | Interrupt request |

## Verification
Counting is exercised in several ways: with steady ticks, with idle cycles between ticks, and with ticks under halt. This separates an edge-driven counter from one that obeys the enable and the freeze. Wraps are driven with a mid-range reload value, with a reload write landing in the middle of a period, with a write on the very wrap edge, and with FFh. These cases tell apart immediate reload, buffered reload, and the old-versus-new choice at the wrap. Status reads are issued alone and on a wrap edge, which shows whether a coincident event is lost, and interrupt enable is toggled around flag set and clear.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
   localparam int STAT_W    = 2;
   localparam int STAT_FLAG = 0;
   localparam int STAT_IE   = 1;

   typedef struct packed {
      logic ie;
      logic flag;
   } tbc_stat_t;
endpackage

// File: rtl/tbc_reload_reg.sv
module tbc_reload_reg #(
   parameter int W       = 8,
   parameter int RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] val_o
);
   localparam logic [W-1:0] RST_W = RST_VAL[W-1:0];

   logic [W-1:0] val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    val_q <= RST_W;
      else if (wr_i) val_q <= wdata_i;
   end

   assign val_o = val_q;

   AST_RELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(val_q)); // R4
endmodule

// File: rtl/tbc_count_core.sv
module tbc_count_core #(
   parameter int W       = 8,
   parameter int RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   input  logic         halt_i,
   input  logic [W-1:0] reload_i,
   output logic [W-1:0] cnt_o,
   output logic         ovf_o
);
   localparam logic [W-1:0] TOP   = '1;
   localparam logic [W-1:0] ONE   = {{(W-1){1'b0}}, 1'b1};
   localparam logic [W-1:0] RST_W = RST_VAL[W-1:0];

   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_d;
   logic         advance;
   logic         at_top;

   assign advance = tick_i & ~halt_i;
   assign at_top  = (cnt_q == TOP);

   always_comb begin
      cnt_d = cnt_q;
      if (advance) begin
         if (at_top) cnt_d = reload_i;
         else        cnt_d = cnt_q + ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= RST_W;
      else        cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;
   assign ovf_o = advance & at_top;

   AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !halt_i && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + ONE)); // R2
   AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(cnt_q)); // R2
   AST_WRAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !halt_i && cnt_q == TOP) |=> (cnt_q == $past(reload_i))); // R3
   AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      halt_i |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/tbc_ovf_status.sv
module tbc_ovf_status
   import tbc_pkg::*;
#(
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ovf_i,
   input  logic      rd_i,
   input  logic      ie_wr_i,
   input  logic      ie_wdata_i,
   output tbc_stat_t stat_o,
   output logic      irq_o
);
   logic flag_q;
   logic ie_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (ovf_i) flag_q <= 1'b1;
      else if (rd_i)  flag_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ie_q <= 1'b0;
      else if (ie_wr_i) ie_q <= ie_wdata_i;
   end

   assign stat_o.flag = flag_q;
   assign stat_o.ie   = ie_q;

   generate
      if (IRQ_REGISTERED) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= flag_q & ie_q;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = flag_q & ie_q;
         AST_IRQ_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_i && ie_q && !ie_wr_i) |=> irq_o); // R8
         AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
            (ie_wr_i && !ie_wdata_i) |=> !irq_o); // R8
      end
   endgenerate

   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_i |=> flag_q); // R3
   AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !ovf_i) |=> !flag_q); // R6
   AST_NO_LOST_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && ovf_i) |=> flag_q); // R7
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_i && flag_q) |=> flag_q); // R6
endmodule

// File: rtl/tbase_reload_counter.sv
module tbase_reload_counter
   import tbc_pkg::*;
#(
   parameter int CNT_W          = 8,
   parameter int RELOAD_RST     = 0,
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              halt_i,
   input  logic              arr_wr_i,
   input  logic [CNT_W-1:0]  arr_wdata_i,
   input  logic              ie_wr_i,
   input  logic              ie_wdata_i,
   input  logic              stat_rd_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [STAT_W-1:0] stat_o,
   output logic              irq_o
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("CNT_W must be in 2..32");
      end
      if (RELOAD_RST < 0 || RELOAD_RST >= (1 << CNT_W)) begin : g_bad_rst
         $error("RELOAD_RST must fit in CNT_W bits");
      end
   endgenerate

   logic [CNT_W-1:0] reload_val;
   logic             ovf_evt;
   tbc_stat_t        stat_s;

   tbc_reload_reg #(
      .W       (CNT_W),
      .RST_VAL (RELOAD_RST)
   ) u_reload (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (arr_wr_i),
      .wdata_i (arr_wdata_i),
      .val_o   (reload_val)
   );

   tbc_count_core #(
      .W       (CNT_W),
      .RST_VAL (RELOAD_RST)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .halt_i   (halt_i),
      .reload_i (reload_val),
      .cnt_o    (cnt_o),
      .ovf_o    (ovf_evt)
   );

   tbc_ovf_status #(
      .IRQ_REGISTERED (IRQ_REGISTERED)
   ) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .ovf_i      (ovf_evt),
      .rd_i       (stat_rd_i),
      .ie_wr_i    (ie_wr_i),
      .ie_wdata_i (ie_wdata_i),
      .stat_o     (stat_s),
      .irq_o      (irq_o)
   );

   assign stat_o = stat_s;

   AST_HALT_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_i && !stat_o[STAT_FLAG]) |=> !stat_o[STAT_FLAG]); // R5
   AST_WRITE_NO_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_wr_i && !tick_i) |=> $stable(cnt_o)); // R4
endmodule

// File: tb/sim_tbase_reload_counter.sv
module sim_tbase_reload_counter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0, halt_i = 1'b0, arr_wr_i = 1'b0;
   logic [7:0] arr_wdata_i = 8'h00;
   logic       ie_wr_i = 1'b0, ie_wdata_i = 1'b0, stat_rd_i = 1'b0;
   logic [7:0] cnt_o;
   logic [1:0] stat_o;
   logic       irq_o;

   always #4 clk = ~clk;

   tbase_reload_counter u0 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .halt_i(halt_i),
      .arr_wr_i(arr_wr_i), .arr_wdata_i(arr_wdata_i),
      .ie_wr_i(ie_wr_i), .ie_wdata_i(ie_wdata_i), .stat_rd_i(stat_rd_i),
      .cnt_o(cnt_o), .stat_o(stat_o), .irq_o(irq_o));

   typedef struct {
      logic [7:0] cnt;
      logic [1:0] stat;
      logic       irq;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   // model state, built from the requirements
   logic [7:0] m_cnt = 8'h00, m_arr = 8'h00;
   logic       m_flag = 1'b0, m_ie = 1'b0;

   task automatic check(input exp_t e);
      n_chk++;
      if (cnt_o !== e.cnt || stat_o !== e.stat || irq_o !== e.irq) begin
         n_bad++;
         $display("FAIL %s: cnt=%02h stat=%b irq=%b expected cnt=%02h stat=%b irq=%b",
                  e.tag, cnt_o, stat_o, irq_o, e.cnt, e.stat, e.irq);
      end
   endtask

   // monitor: pops expected items as results appear
   always @(negedge clk) begin
      if (q.size() > 0) check(q.pop_front());
   end

   // driver: applies one cycle and pushes what must follow it
   task automatic step(input bit tk, input bit hl, input bit wr, input logic [7:0] wd,
                       input bit iw, input bit iv, input bit rd, input string tag);
      bit   ovf;
      exp_t e;
      tick_i = tk; halt_i = hl; arr_wr_i = wr; arr_wdata_i = wd;
      ie_wr_i = iw; ie_wdata_i = iv; stat_rd_i = rd;
      @(posedge clk);
      ovf = tk && !hl && (m_cnt == 8'hFF);
      if (tk && !hl) m_cnt = ovf ? m_arr : m_cnt + 8'd1;
      if (ovf) m_flag = 1'b1;
      else if (rd) m_flag = 1'b0;
      if (wr) m_arr = wd;
      if (iw) m_ie = iv;
      e.cnt = m_cnt; e.stat = {m_ie, m_flag}; e.irq = m_flag & m_ie; e.tag = tag;
      q.push_back(e);
      @(negedge clk);
      #1;
   endtask

   task automatic ticks(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1, 0, 0, 8'h00, 0, 0, 0, tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
   end

   initial begin
      exp_t r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      r.cnt = 8'h00; r.stat = 2'b00; r.irq = 1'b0; r.tag = "R1 reset state";
      check(r);
      ticks(5, "R2 steady ticks");
      step(0, 0, 0, 8'h00, 0, 0, 0, "R2 idle hold");
      step(0, 0, 0, 8'h00, 0, 0, 0, "R2 idle hold");
      step(1, 0, 0, 8'h00, 0, 0, 0, "R2 tick after idle");
      for (int i = 0; i < 4; i++) step(1, 1, 0, 8'h00, 0, 0, 0, "R5 halt with ticks");
      step(1, 0, 1, 8'hFC, 0, 0, 0, "R4 write does not move counter");
      ticks(255 - 7, "R2 run to top");
      step(0, 0, 0, 8'h00, 1, 1, 0, "R8 enable with flag clear");
      step(1, 0, 0, 8'h00, 0, 0, 0, "R3 wrap to reload, R8 irq");
      step(0, 0, 0, 8'h00, 0, 0, 1, "R6 read clears flag");
      ticks(3, "R2 climb to top");
      step(1, 0, 0, 8'h00, 0, 0, 1, "R7 wrap with read keeps flag");
      step(0, 0, 0, 8'h00, 1, 0, 1, "R6 clear, R8 disable");
      ticks(3, "R2 climb to top");
      step(1, 0, 1, 8'h20, 0, 0, 0, "R4 write on wrap uses old value");
      step(0, 0, 0, 8'h00, 0, 0, 1, "R6 read clears flag");
      step(1, 0, 1, 8'hFF, 0, 0, 0, "R4 mid-period write");
      ticks(2, "R2 climb to top");
      step(1, 0, 0, 8'h00, 0, 0, 0, "R4 new reload at next wrap");
      step(0, 0, 0, 8'h00, 1, 1, 1, "R6 clear, R8 enable");
      for (int i = 0; i < 4; i++) step(1, 0, 0, 8'h00, 0, 0, 1, "R9 overflow every tick");
      step(1, 1, 0, 8'h00, 0, 0, 1, "R5 halt at top, read clears");
      step(1, 1, 0, 8'h00, 0, 0, 0, "R5 halt no new flag");
      step(1, 0, 0, 8'h00, 0, 0, 0, "R9 overflow after halt");
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule